// File: doc/BRIEF.md
# Host/BMC Byte Mailbox Registers

This unit is a pair of one-byte mailboxes with a shared eight-bit status register. It sits between a host processor and a management controller (BMC). The host pushes bytes toward the BMC and the BMC pushes bytes back. Each direction has a buffer-full flag, and the flag doubles as a level interrupt toward the reader. Reading the data register is how the reader acknowledges the byte and drops the interrupt.

Each side has a port with read and write strobes and a one-bit address. Address 0 selects the data register. Address 1 selects the status register on reads. On writes, address 1 means something different on each side:

- For the host, it writes a command byte. The command byte lands in the same inbound buffer, and a hardware flag records that it was a command.
- For the BMC, it writes the protocol bits that software owns.

Writing status never raises an interrupt. To get the host's attention after a status change, BMC firmware has to follow the status write with a data write. Bus decoding, address mapping and interrupt serialisation all sit outside this block.

Top module: `hbmb_mailbox`

## Requirements
- R1: A synchronous active-high reset clears both data bytes, every status bit, both overrun bits and both interrupts. After reset, a status read on either side returns 0x00.
- R2: Any host write sets status bit 1 (inbound full) and stores the byte. A host write at address 0 clears status bit 3. A host write at address 1 sets status bit 3, marking the byte as a command.
- R3: A BMC read at address 0 returns the stored inbound byte in the same cycle. It clears status bit 1 at the next clock edge, unless a host write lands in that same cycle.
- R4: A BMC write at address 0 stores the byte and sets status bit 0 (outbound full). A host read at address 0 returns that byte in the same cycle and clears bit 0 at the next edge.
- R5: A BMC write at address 1 loads only the software-owned status bits 7, 6, 5, 4 and 2. Bits 3, 1 and 0 keep their values.
- R6: A BMC status write raises no interrupt and never sets a buffer-full flag.
- R7: With the default zero interrupt latency, `bmc_irq` equals status bit 1 and `host_irq` equals status bit 0, on every cycle.
- R8: A write into a full buffer replaces the stored byte and leaves the flag set. It also sets the writer's overrun bit (`host_overrun` or `bmc_overrun`), which then holds until reset. A write in the same cycle that the reader empties the buffer is not an overrun.
- R9: A status read returns the same byte on both sides in the same cycle.
- R10: A status read clears no flag and changes no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 1 | Host address: 0 selects data, 1 selects status/command |
| host_wdata | input | DATA_W | Host write byte |
| host_rdata | output | DATA_W | Host read byte, valid while `host_rd` is high, zero otherwise |
| host_irq | output | 1 | Host interrupt level, tracks outbound full |
| host_overrun | output | 1 | Sticky: the host wrote into a full inbound buffer |
| bmc_wr | input | 1 | BMC write strobe |
| bmc_rd | input | 1 | BMC read strobe |
| bmc_addr | input | 1 | BMC address: 0 selects data, 1 selects status |
| bmc_wdata | input | DATA_W | BMC write byte |
| bmc_rdata | output | DATA_W | BMC read byte, valid while `bmc_rd` is high, zero otherwise |
| bmc_irq | output | 1 | BMC interrupt level, tracks inbound full |
| bmc_overrun | output | 1 | Sticky: the BMC wrote into a full outbound buffer |

## Verification
The bound checker watches the flag rules on every cycle:

- each write sets its flag, and each uncontested data read clears it;
- status writes keep the command flag and raise no interrupt;
- each interrupt tracks its flag;
- an overrun bit rises only after a write into a full buffer, and then stays set.

Other behaviour shows only in the bench's scenarios:

- the exact status byte that each sequence of writes builds;
- that the overwritten byte is the one read back;
- that both sides see the same status value;
- that a write in the same cycle as a read still returns the old byte.

// File: rtl/mb_pkg.sv
package mb_pkg;
   localparam int STAT_W       = 8;
   localparam int BIT_OUT_FULL = 0;
   localparam int BIT_IN_FULL  = 1;
   localparam int BIT_CMD      = 3;
   localparam logic [STAT_W-1:0] HW_MASK =
      (8'h1 << BIT_OUT_FULL) | (8'h1 << BIT_IN_FULL) | (8'h1 << BIT_CMD);
   localparam logic [STAT_W-1:0] SW_MASK_DEF = 8'hF4;
   localparam logic ADDR_DATA = 1'b0;
   localparam logic ADDR_CTRL = 1'b1;
   typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/mb_slot.sv
module mb_slot #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_en,
   output logic [DATA_W-1:0] data,
   output logic              full,
   output logic              overrun
);
   always_ff @(posedge clk) begin
      if (rst) begin
         data    <= '0;
         full    <= 1'b0;
         overrun <= 1'b0;
      end else begin
         if (wr_en) begin
            data <= wdata;
            full <= 1'b1;
            if (full && !rd_en) overrun <= 1'b1;
         end else if (rd_en) begin
            full <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/mb_ctrl.sv
module mb_ctrl
   import mb_pkg::*;
#(
   parameter stat_t SW_MASK = SW_MASK_DEF
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  host_wr,
   input  logic  host_is_cmd,
   input  logic  sw_wr,
   input  stat_t sw_wdata,
   output stat_t sw_bits,
   output logic  cmd_flag
);
   always_ff @(posedge clk) begin
      if (rst) begin
         sw_bits  <= '0;
         cmd_flag <= 1'b0;
      end else begin
         if (sw_wr)   sw_bits  <= sw_wdata & SW_MASK;
         if (host_wr) cmd_flag <= host_is_cmd;
      end
   end
endmodule

// File: rtl/mb_irq.sv
module mb_irq #(
   parameter int LATENCY = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic flag,
   output logic irq
);
   generate
      if (LATENCY == 0) begin : g_direct
         assign irq = flag;
      end else begin : g_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (rst) irq_q <= 1'b0;
            else     irq_q <= flag;
         end
         assign irq = irq_q;
      end
   endgenerate
endmodule

// File: rtl/hbmb_mailbox.sv
module hbmb_mailbox
   import mb_pkg::*;
#(
   parameter int    DATA_W  = 8,
   parameter stat_t SW_MASK = SW_MASK_DEF,
   parameter int    IRQ_LAT = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic              host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_irq,
   output logic              host_overrun,
   input  logic              bmc_wr,
   input  logic              bmc_rd,
   input  logic              bmc_addr,
   input  logic [DATA_W-1:0] bmc_wdata,
   output logic [DATA_W-1:0] bmc_rdata,
   output logic              bmc_irq,
   output logic              bmc_overrun
);
   localparam int PAD_W = DATA_W - STAT_W;

   if (DATA_W < STAT_W) begin : g_chk_w
      $error("DATA_W must hold the status byte");
   end
   if ((SW_MASK & HW_MASK) != '0) begin : g_chk_mask
      $error("SW_MASK overlaps hardware-owned status bits");
   end
   if (IRQ_LAT < 0 || IRQ_LAT > 1) begin : g_chk_lat
      $error("IRQ_LAT must be 0 or 1");
   end

   logic              in_rd, out_wr, out_rd, sw_wr;
   logic [DATA_W-1:0] in_data, out_data;
   logic              in_full, out_full, cmd_flag;
   stat_t             sw_bits, status;
   logic [DATA_W-1:0] status_w;

   assign in_rd  = bmc_rd  && (bmc_addr  == ADDR_DATA);
   assign out_wr = bmc_wr  && (bmc_addr  == ADDR_DATA);
   assign out_rd = host_rd && (host_addr == ADDR_DATA);
   assign sw_wr  = bmc_wr  && (bmc_addr  == ADDR_CTRL);

   mb_slot #(.DATA_W(DATA_W)) u_in (
      .clk(clk), .rst(rst), .wr_en(host_wr), .wdata(host_wdata),
      .rd_en(in_rd), .data(in_data), .full(in_full), .overrun(host_overrun)
   );

   mb_slot #(.DATA_W(DATA_W)) u_out (
      .clk(clk), .rst(rst), .wr_en(out_wr), .wdata(bmc_wdata),
      .rd_en(out_rd), .data(out_data), .full(out_full), .overrun(bmc_overrun)
   );

   mb_ctrl #(.SW_MASK(SW_MASK)) u_ctrl (
      .clk(clk), .rst(rst), .host_wr(host_wr),
      .host_is_cmd(host_addr == ADDR_CTRL),
      .sw_wr(sw_wr), .sw_wdata(bmc_wdata[STAT_W-1:0]),
      .sw_bits(sw_bits), .cmd_flag(cmd_flag)
   );

   always_comb begin
      status = sw_bits;
      status[BIT_CMD]      = cmd_flag;
      status[BIT_IN_FULL]  = in_full;
      status[BIT_OUT_FULL] = out_full;
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign status_w = {{PAD_W{1'b0}}, status};
      end else begin : g_nopad
         assign status_w = status;
      end
   endgenerate

   assign host_rdata = !host_rd ? '0 : (host_addr == ADDR_CTRL) ? status_w : out_data;
   assign bmc_rdata  = !bmc_rd  ? '0 : (bmc_addr  == ADDR_CTRL) ? status_w : in_data;

   mb_irq #(.LATENCY(IRQ_LAT)) u_bmc_irq (
      .clk(clk), .rst(rst), .flag(in_full), .irq(bmc_irq)
   );
   mb_irq #(.LATENCY(IRQ_LAT)) u_host_irq (
      .clk(clk), .rst(rst), .flag(out_full), .irq(host_irq)
   );
endmodule

// File: rtl/mb_checker.sv
module mb_checker #(
   parameter int IRQ_LAT = 0
) (
   input logic clk,
   input logic rst,
   input logic host_wr,
   input logic host_rd,
   input logic host_addr,
   input logic bmc_wr,
   input logic bmc_rd,
   input logic bmc_addr,
   input logic host_irq,
   input logic bmc_irq,
   input logic host_overrun,
   input logic bmc_overrun,
   input logic in_full,
   input logic out_full,
   input logic cmd_flag
);
   logic b_dat_rd, b_dat_wr, b_st_wr, h_dat_rd;
   assign b_dat_rd = bmc_rd  && !bmc_addr;
   assign b_dat_wr = bmc_wr  && !bmc_addr;
   assign b_st_wr  = bmc_wr  &&  bmc_addr;
   assign h_dat_rd = host_rd && !host_addr;

   p_in_set_r2: assert property (@(posedge clk) disable iff (rst)
      host_wr |=> in_full);
   p_in_clear_r3: assert property (@(posedge clk) disable iff (rst)
      (b_dat_rd && !host_wr) |=> !in_full);
   p_out_set_r4: assert property (@(posedge clk) disable iff (rst)
      b_dat_wr |=> out_full);
   p_out_clear_r4: assert property (@(posedge clk) disable iff (rst)
      (h_dat_rd && !b_dat_wr) |=> !out_full);
   p_hw_bits_kept_r5: assert property (@(posedge clk) disable iff (rst)
      (b_st_wr && !host_wr) |=> $stable(cmd_flag));
   p_no_irq_status_r6: assert property (@(posedge clk) disable iff (rst)
      (b_st_wr && !out_full) |=> !out_full);
   p_ovr_sticky_host_r8: assert property (@(posedge clk) disable iff (rst)
      host_overrun |=> host_overrun);
   p_ovr_sticky_bmc_r8: assert property (@(posedge clk) disable iff (rst)
      bmc_overrun |=> bmc_overrun);
   p_ovr_cause_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(host_overrun) |-> $past(host_wr && in_full && !b_dat_rd));

   generate
      if (IRQ_LAT == 0) begin : g_lvl
         p_bmc_irq_r7: assert property (@(posedge clk) disable iff (rst)
            bmc_irq == in_full);
         p_host_irq_r7: assert property (@(posedge clk) disable iff (rst)
            host_irq == out_full);
      end else begin : g_dly
         p_bmc_irq_r7: assert property (@(posedge clk) disable iff (rst)
            bmc_irq == $past(in_full));
         p_host_irq_r7: assert property (@(posedge clk) disable iff (rst)
            host_irq == $past(out_full));
      end
   endgenerate
endmodule

bind hbmb_mailbox mb_checker #(.IRQ_LAT(IRQ_LAT)) u_mb_checker (
   .clk(clk), .rst(rst),
   .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
   .bmc_wr(bmc_wr), .bmc_rd(bmc_rd), .bmc_addr(bmc_addr),
   .host_irq(host_irq), .bmc_irq(bmc_irq),
   .host_overrun(host_overrun), .bmc_overrun(bmc_overrun),
   .in_full(in_full), .out_full(out_full), .cmd_flag(cmd_flag)
);

// File: tb/test_hbmb_mailbox.sv
module test_hbmb_mailbox;
   logic       clk = 1'b0;
   logic       rst;
   logic       host_wr, host_rd, host_addr;
   logic [7:0] host_wdata, host_rdata;
   logic       host_irq, host_overrun;
   logic       bmc_wr, bmc_rd, bmc_addr;
   logic [7:0] bmc_wdata, bmc_rdata;
   logic       bmc_irq, bmc_overrun;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   hbmb_mailbox i_hbmb_mailbox (
      .clk(clk), .rst(rst),
      .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_irq(host_irq), .host_overrun(host_overrun),
      .bmc_wr(bmc_wr), .bmc_rd(bmc_rd), .bmc_addr(bmc_addr),
      .bmc_wdata(bmc_wdata), .bmc_rdata(bmc_rdata),
      .bmc_irq(bmc_irq), .bmc_overrun(bmc_overrun)
   );

   typedef struct packed {
      logic       hw, hr, ha;
      logic [7:0] hd;
      logic       bw, br, ba;
      logic [7:0] bd;
      logic [7:0] hq, bq;
      logic       hi, bi;
   } vec_t;

   localparam vec_t VECS [14] = '{
      '{1'b0,1'b0,1'b0,8'h00, 1'b1,1'b0,1'b1,8'hC0, 8'h00,8'h00, 1'b0,1'b0}, // R5 R6
      '{1'b0,1'b1,1'b1,8'h00, 1'b0,1'b1,1'b1,8'h00, 8'hC0,8'hC0, 1'b0,1'b0}, // R9
      '{1'b1,1'b0,1'b0,8'h5A, 1'b0,1'b0,1'b0,8'h00, 8'h00,8'h00, 1'b0,1'b1}, // R2 R7
      '{1'b0,1'b1,1'b1,8'h00, 1'b0,1'b1,1'b1,8'h00, 8'hC2,8'hC2, 1'b0,1'b1}, // R10 R9
      '{1'b0,1'b0,1'b0,8'h00, 1'b0,1'b1,1'b0,8'h00, 8'h00,8'h5A, 1'b0,1'b0}, // R3
      '{1'b1,1'b0,1'b1,8'h01, 1'b0,1'b0,1'b0,8'h00, 8'h00,8'h00, 1'b0,1'b1}, // R2 command
      '{1'b0,1'b0,1'b0,8'h00, 1'b1,1'b0,1'b1,8'hFF, 8'h00,8'h00, 1'b0,1'b1}, // R5 R6
      '{1'b0,1'b1,1'b1,8'h00, 1'b0,1'b1,1'b1,8'h00, 8'hFE,8'hFE, 1'b0,1'b1}, // R5
      '{1'b0,1'b0,1'b0,8'h00, 1'b1,1'b0,1'b1,8'h00, 8'h00,8'h00, 1'b0,1'b1}, // R5
      '{1'b0,1'b0,1'b0,8'h00, 1'b1,1'b1,1'b0,8'h33, 8'h00,8'h01, 1'b1,1'b0}, // R3 R4 R7
      '{1'b0,1'b1,1'b1,8'h00, 1'b0,1'b0,1'b0,8'h00, 8'h09,8'h00, 1'b1,1'b0}, // R5 R10
      '{1'b0,1'b1,1'b0,8'h00, 1'b0,1'b0,1'b0,8'h00, 8'h33,8'h00, 1'b0,1'b0}, // R4
      '{1'b1,1'b0,1'b0,8'h10, 1'b0,1'b0,1'b0,8'h00, 8'h00,8'h00, 1'b0,1'b1}, // R2
      '{1'b0,1'b0,1'b0,8'h00, 1'b0,1'b1,1'b1,8'h00, 8'h00,8'h02, 1'b0,1'b1}  // R2 R10
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0;
      bmc_wr = 0;  bmc_rd = 0;  bmc_addr = 0;  bmc_wdata = 0;
   endtask

   // Called just after a falling edge; returns just after the next falling edge.
   task automatic step(input vec_t v, input string tag);
      host_wr = v.hw; host_rd = v.hr; host_addr = v.ha; host_wdata = v.hd;
      bmc_wr = v.bw;  bmc_rd = v.br;  bmc_addr = v.ba;  bmc_wdata = v.bd;
      #1;
      if (v.hr) chk({tag, " host_rdata"}, host_rdata, v.hq);
      if (v.br) chk({tag, " bmc_rdata"}, bmc_rdata, v.bq);
      @(posedge clk); #1;
      idle();
      chk({tag, " host_irq"}, {7'b0, host_irq}, {7'b0, v.hi});
      chk({tag, " bmc_irq"}, {7'b0, bmc_irq}, {7'b0, v.bi});
      @(negedge clk); #1;
   endtask

   function automatic vec_t mk(logic hw, logic hr, logic ha, logic [7:0] hd,
                               logic bw, logic br, logic ba, logic [7:0] bd,
                               logic [7:0] hq, logic [7:0] bq, logic hi, logic bi);
      return '{hw, hr, ha, hd, bw, br, ba, bd, hq, bq, hi, bi};
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      idle();
      rst = 1;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 0; #1;
      // R1: reset state
      chk("R1 host_irq", {7'b0, host_irq}, 8'h00);
      chk("R1 bmc_irq", {7'b0, bmc_irq}, 8'h00);
      chk("R1 overruns", {6'b0, host_overrun, bmc_overrun}, 8'h00);
      step(mk(0,1,1,0, 0,1,1,0, 8'h00,8'h00, 0,0), "R1 status");

      for (int i = 0; i < 14; i++) step(VECS[i], $sformatf("table %0d", i));

      // R3 drain the leftover inbound byte
      step(mk(0,0,0,0, 0,1,0,0, 8'h00,8'h10, 0,0), "R3 drain");
      // R8: write and read of inbound buffer in one cycle is not an overrun
      step(mk(1,0,0,8'h44, 0,0,0,0, 0,0, 0,1), "R8 fill");
      step(mk(1,0,0,8'h55, 0,1,0,0, 8'h00,8'h44, 0,1), "R8 same-cycle");
      chk("R8 no host overrun", {7'b0, host_overrun}, 8'h00);
      step(mk(0,0,0,0, 0,1,0,0, 8'h00,8'h55, 0,0), "R8 read new");
      // R8: real inbound overrun
      step(mk(1,0,0,8'h20, 0,0,0,0, 0,0, 0,1), "R8 fill2");
      step(mk(1,0,0,8'h21, 0,0,0,0, 0,0, 0,1), "R8 overwrite");
      chk("R8 host overrun set", {7'b0, host_overrun}, 8'h01);
      step(mk(0,0,0,0, 0,1,0,0, 8'h00,8'h21, 0,0), "R8 overwritten byte");
      chk("R8 host overrun sticky", {7'b0, host_overrun}, 8'h01);
      // R8: outbound overrun
      step(mk(0,0,0,0, 1,0,0,8'h70, 0,0, 1,0), "R8 out fill");
      chk("R8 no bmc overrun yet", {7'b0, bmc_overrun}, 8'h00);
      step(mk(0,0,0,0, 1,0,0,8'h71, 0,0, 1,0), "R8 out overwrite");
      chk("R8 bmc overrun set", {7'b0, bmc_overrun}, 8'h01);
      step(mk(0,1,0,0, 0,0,0,0, 8'h71,8'h00, 0,0), "R8 out read");

      // R1: reset clears everything again
      step(mk(1,0,1,8'h9C, 1,0,1,8'hF4, 0,0, 0,1), "R1 preload");
      step(mk(0,0,0,0, 1,0,0,8'h66, 0,0, 1,1), "R1 preload2");
      rst = 1;
      @(posedge clk); @(negedge clk); rst = 0; #1;
      chk("R1 post host_irq", {7'b0, host_irq}, 8'h00);
      chk("R1 post bmc_irq", {7'b0, bmc_irq}, 8'h00);
      chk("R1 post overruns", {6'b0, host_overrun, bmc_overrun}, 8'h00);
      step(mk(0,1,1,0, 0,1,1,0, 8'h00,8'h00, 0,0), "R1 post status");
      step(mk(0,1,0,0, 0,1,0,0, 8'h00,8'h00, 0,0), "R1 post data");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule